// File: doc/BRIEF.md
# Byte Program Retry Sequencer

This block is a host-side controller that writes a single byte into a command-driven flash array. It drives a small bus master port with address, write data, read data, a write strobe and a read strobe. A start request latches a target address and a data byte. The block then runs program attempts until the byte reads back correctly or an attempt limit is reached.

Each attempt has a fixed order. The block writes the program-setup command and then the data byte to the target address; that data write starts the programming pulse. The block waits a programmable number of cycles for the pulse, writes the verify command, waits a short settle time and reads the byte back. If the byte read back matches, the block stops. If it does not match, the block starts another attempt. When the work ends either way, the block writes the read-mode command so the flash returns to normal reads. It then reports the result with a one-cycle done pulse or a one-cycle fail pulse.

The programming voltage is raised outside this block. Electrical bus timing is also outside its scope.

Top module: `prog_retry_seq`

## Requirements
- R1: After reset, busy, done, fail, bus_wr and bus_rd are all low. While idle, neither strobe is raised.
- R2: Every attempt begins with two write strobes on consecutive cycles, both at the latched address. The first carries 8'h40 (program setup). The second carries the latched data byte.
- R3: Exactly PULSE_CYC cycles with no strobe lie between the data write and the write of 8'hC0 (program verify).
- R4: Exactly SETTLE_CYC cycles with no strobe lie between the 8'hC0 write and a one-cycle read strobe at the latched address. The block compares bus_rdata in the cycle after the read strobe.
- R5: If the read-back byte equals the latched data, no further 8'h40 is written and done pulses for one cycle.
- R6: If the read-back byte differs, a new attempt starts, up to MAX_TRIES attempts in total (default 25). After MAX_TRIES mismatches, fail pulses for one cycle and no further 8'h40 is written.
- R7: After the outcome is decided, the block writes 8'h00 (read mode) exactly once. Done or fail rises in the cycle directly after that write. Done and fail are never high together.
- R8: Busy is high from the cycle after an accepted start until the cycle in which done or fail is high. In that cycle busy is low.
- R9: A start raised while busy is ignored. Every strobe of the running job keeps the originally latched address and data.
- R10: bus_wr and bus_rd are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to program one byte; sampled when idle |
| start_addr | input | ADDR_W | Target address latched on start |
| start_data | input | DATA_W | Byte latched on start |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse: byte verified |
| fail | output | 1 | One-cycle pulse: attempt limit exhausted |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_wr | output | 1 | Write strobe, one cycle per write |
| bus_rd | output | 1 | Read strobe; data returns the next cycle |
| bus_rdata | input | DATA_W | Read data, valid the cycle after bus_rd |

## Verification
The bench drives a flash model that starts returning the correct byte only after a chosen number of pulses. This covers several cases:
- Success on the first attempt.
- Success on the very last allowed attempt. An off-by-one limit would report fail here instead of done.
- One pulse beyond the limit. A loose bound would keep pulsing instead of failing.

Gap checks cover both waits: a timer that loaded the wrong count would shift the verify write or the read strobe by a cycle. A start raised during a job, carrying a different address and byte, would redirect later writes if the block re-latched its inputs. The bench also times done against the read-mode write, which shows a result reported too early or a missing 00h write.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOAD,
        ST_PULSE,
        ST_VCMD,
        ST_SETTLE,
        ST_READ,
        ST_CMP,
        ST_EXIT
    } seq_state_t;

    localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
    localparam logic [7:0] CMD_PROG_VERIFY = 8'hC0;
    localparam logic [7:0] CMD_READ_MODE   = 8'h00;

endpackage

// File: rtl/prog_seq_timer.sv
module prog_seq_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R3 / R4: wait states only request a decrement while time remains
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec && expired));
endmodule

// File: rtl/prog_seq_tries.sv
module prog_seq_tries #(
    parameter int MAX_TRIES = 25,
    localparam int TW = $clog2(MAX_TRIES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [TW-1:0] count,
    output logic          at_limit
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count    = cnt_q;
    assign at_limit = (cnt_q == TW'(MAX_TRIES));

    a_r6_tries_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TW'(MAX_TRIES));
    a_r6_no_inc_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && at_limit));
endmodule

// File: rtl/prog_retry_seq.sv
module prog_retry_seq
    import prog_seq_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 8,
    parameter int PULSE_CYC  = 1250,
    parameter int SETTLE_CYC = 4,
    parameter int MAX_TRIES  = 25,
    localparam int LONGEST   = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC,
    localparam int CNT_W     = $clog2(LONGEST + 1),
    localparam int TW        = $clog2(MAX_TRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_data,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata
);
    typedef struct packed {
        seq_state_t        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              pass;
        logic              done;
        logic              fail;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    logic             tmr_load, tmr_dec, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic             try_clr, try_inc, try_at_limit;
    logic [TW-1:0]    try_count;

    prog_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .expired  (tmr_expired)
    );

    prog_seq_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (try_clr),
        .inc      (try_inc),
        .count    (try_count),
        .at_limit (try_at_limit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.fail = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        try_clr  = 1'b0;
        try_inc  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.addr = start_addr;
                    r_d.data = start_data;
                    r_d.pass = 1'b0;
                    r_d.st   = ST_SETUP;
                    try_clr  = 1'b1;
                end
            end
            ST_SETUP: r_d.st = ST_LOAD;
            ST_LOAD: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(PULSE_CYC - 1);
                try_inc  = 1'b1;
                r_d.st   = ST_PULSE;
            end
            ST_PULSE: begin
                if (tmr_expired) r_d.st = ST_VCMD;
                else             tmr_dec = 1'b1;
            end
            ST_VCMD: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(SETTLE_CYC - 1);
                r_d.st   = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tmr_expired) r_d.st = ST_READ;
                else             tmr_dec = 1'b1;
            end
            ST_READ: r_d.st = ST_CMP;
            ST_CMP: begin
                if (bus_rdata == r_q.data) begin
                    r_d.pass = 1'b1;
                    r_d.st   = ST_EXIT;
                end else if (try_at_limit) begin
                    r_d.pass = 1'b0;
                    r_d.st   = ST_EXIT;
                end else begin
                    r_d.st   = ST_SETUP;
                end
            end
            ST_EXIT: begin
                r_d.done = r_q.pass;
                r_d.fail = !r_q.pass;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, data: '0, pass: 1'b0,
                     done: 1'b0, fail: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        bus_wdata = '0;
        unique case (r_q.st)
            ST_SETUP: begin bus_wr = 1'b1; bus_wdata = DATA_W'(CMD_PROG_SETUP);  end
            ST_LOAD:  begin bus_wr = 1'b1; bus_wdata = r_q.data;                 end
            ST_VCMD:  begin bus_wr = 1'b1; bus_wdata = DATA_W'(CMD_PROG_VERIFY); end
            ST_EXIT:  begin bus_wr = 1'b1; bus_wdata = DATA_W'(CMD_READ_MODE);   end
            ST_READ:  bus_rd = 1'b1;
            default: ;
        endcase
    end

    assign bus_addr = r_q.addr;
    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign fail     = r_q.fail;

    initial begin
        a_r3_params: assert (PULSE_CYC >= 1 && SETTLE_CYC >= 1 && MAX_TRIES >= 1);
    end

    a_r10_no_wr_rd_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));
    a_r7_done_fail_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));
    a_r7_result_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> ($past(bus_wr) && $past(bus_wdata) == DATA_W'(CMD_READ_MODE)));
    a_r8_idle_when_reporting: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> !busy);
    a_r6_fail_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> try_at_limit);
    a_r9_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(bus_addr)));
    a_r3_verify_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_VCMD) |-> ($past(r_q.st) == ST_PULSE && $past(tmr_expired)));
endmodule

// File: tb/prog_retry_seq_tb.sv
module prog_retry_seq_tb;
    localparam int AW = 18;
    localparam int DW = 8;
    localparam int PULSE = 20;
    localparam int SETTLE = 3;
    localparam int MAXT = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [DW-1:0] start_data = '0;
    logic busy, done, fail, bus_wr, bus_rd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;

    always #4 clk = ~clk;

    prog_retry_seq #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PULSE),
                     .SETTLE_CYC(SETTLE), .MAX_TRIES(MAXT)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_data(start_data), .busy(busy), .done(done), .fail(fail),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata));

    int n_checks = 0;
    int n_fail = 0;

    // job parameters, driven only by the initial block
    logic          clr = 1'b0;
    logic [AW-1:0] exp_addr = '0;
    logic [DW-1:0] exp_data = '0;
    int            need_pulses = 1;

    // flash model
    int   pulses;
    logic armed;
    always @(posedge clk) begin
        if (clr) begin
            pulses <= 0; armed <= 1'b0; bus_rdata <= '0;
        end else begin
            if (bus_wr) begin
                if (armed) begin
                    armed <= 1'b0;
                    pulses <= pulses + 1;
                end else if (bus_wdata == 8'h40) begin
                    armed <= 1'b1;
                end
            end
            if (bus_rd)
                bus_rdata <= (pulses >= need_pulses) ? exp_data : (exp_data ^ 8'hA5);
        end
    end

    // bus monitor
    int cyc, data_cyc, vcmd_cyc, exit_cyc, res_cyc;
    int n_setup, n_exit, n_done, n_fail_p;
    int e_r2, e_r3, e_r4, e_r8, e_r9, e_r10, e_after;
    logic want_data, in_run;
    always @(negedge clk) begin
        if (clr) begin
            cyc = 0; data_cyc = 0; vcmd_cyc = 0; exit_cyc = -1; res_cyc = -1;
            n_setup = 0; n_exit = 0; n_done = 0; n_fail_p = 0;
            e_r2 = 0; e_r3 = 0; e_r4 = 0; e_r8 = 0; e_r9 = 0; e_r10 = 0; e_after = 0;
            want_data = 1'b0; in_run = 1'b0;
        end else begin
            cyc++;
            if (busy) in_run = 1'b1;
            if (bus_wr && bus_rd) e_r10++;
            if ((bus_wr || bus_rd) && bus_addr != exp_addr) e_r9++;
            if (bus_wr && res_cyc >= 0) e_after++;
            if (want_data) begin
                if (!bus_wr || bus_wdata != exp_data) e_r2++;
                data_cyc = cyc;
                want_data = 1'b0;
            end else if (bus_wr) begin
                case (bus_wdata)
                    8'h40: begin n_setup++; want_data = 1'b1; end
                    8'hC0: begin
                        if (cyc - data_cyc - 1 != PULSE) e_r3++;
                        vcmd_cyc = cyc;
                    end
                    8'h00: begin n_exit++; exit_cyc = cyc; end
                    default: e_r2++;
                endcase
            end
            if (bus_rd && (cyc - vcmd_cyc - 1 != SETTLE)) e_r4++;
            if (done || fail) begin
                if (res_cyc < 0) res_cyc = cyc;
                if (done) n_done++;
                if (fail) n_fail_p++;
                if (busy) e_r8++;
            end else if (in_run && res_cyc < 0 && !busy) begin
                e_r8++;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_job(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int k, input bit poke);
        int tries_exp;
        bit ok_exp;
        bit timed_out;
        @(negedge clk);
        clr = 1'b1; exp_addr = a; exp_data = d; need_pulses = k;
        @(negedge clk);
        clr = 1'b0;
        start = 1'b1; start_addr = a; start_data = d;
        @(negedge clk);
        start = 1'b0;
        check("R8 busy after start", int'(busy), 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            start = 1'b1; start_addr = ~a; start_data = ~d;
            @(negedge clk);
            start = 1'b0;
        end
        timed_out = 1'b1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (res_cyc >= 0) begin timed_out = 1'b0; break; end
        end
        repeat (6) @(negedge clk);
        check("R6 watchdog", int'(timed_out), 0);
        tries_exp = (k <= MAXT) ? k : MAXT;
        ok_exp = (k <= MAXT);
        check("R5/R6 attempts", n_setup, tries_exp);
        check("R5 done pulses", n_done, ok_exp ? 1 : 0);
        check("R6 fail pulses", n_fail_p, ok_exp ? 0 : 1);
        check("R7 exit writes", n_exit, 1);
        check("R7 result timing", res_cyc - exit_cyc, 1);
        check("R7 quiet after result", e_after, 0);
        check("R2 order", e_r2, 0);
        check("R3 pulse gap", e_r3, 0);
        check("R4 settle gap", e_r4, 0);
        check("R8 busy window", e_r8, 0);
        check("R9 latched target", e_r9, 0);
        check("R10 strobe overlap", e_r10, 0);
        check("R8 idle after", int'(busy), 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_1234);
        clr = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 busy reset", int'(busy), 0);
        check("R1 done reset", int'(done), 0);
        check("R1 fail reset", int'(fail), 0);
        check("R1 wr reset", int'(bus_wr), 0);
        check("R1 rd reset", int'(bus_rd), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 idle strobes", int'(bus_wr | bus_rd), 0);
        // directed corners
        run_job(18'h00000, 8'h40, 1, 1'b0);      // R5 first try, data equals a command code
        run_job(18'h3FFFF, 8'h00, MAXT, 1'b0);   // R6 success on final try
        run_job(18'h12345, 8'hC0, MAXT + 1, 1'b0); // R6 limit exhausted
        run_job(18'h0ABCD, 8'h5A, 3, 1'b1);      // R9 start while busy
        // random jobs
        for (int j = 0; j < 8; j++) begin
            run_job(AW'($urandom), DW'($urandom), 1 + int'($urandom % 30), bit'($urandom % 2));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R6 watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule